// File: doc/BRIEF.md
# Selectable-Style Clock Gate

This block gates a clock under an enable. One of four gating styles is picked when the design is elaborated. Two styles hold the enable in a latch before the gate, so that an enable which moves at any time cannot shorten or split a clock pulse. The other two styles are a bare gate, for places where a register upstream already keeps the enable steady for the right phase. The styles differ in the level the gated clock rests at while it is off. They also differ in the clock edge of the downstream logic and the kind of latch that the gated clock may safely drive.

The effective enable is the functional enable ORed with a scan enable, so scan mode always lets the clock through. On the path from the clock input to the gated clock there is exactly one two-input gate, and there is no pipeline stage anywhere. The style parameter takes the values 0 to 3. Any other value stops elaboration with an error.

The low-latch style (0) suits rising-edge logic. It must not clock a latch that is open while its clock is low, because such a latch would stay open while the clock is gated. The high-latch style (2) suits falling-edge logic. It must not clock a latch that is open while its clock is high.

Top module: `clk_gate_sel`

## Requirements
- R1: With STYLE = 0, the effective enable passes through a latch that is open while clk_in is low, and gclk_out = clk_in AND the latched value. gclk_out rests LOW while the enable is off.
- R2: With STYLE = 1, gclk_out = clk_in OR NOT(effective enable), with no latch. gclk_out rests HIGH while the enable is off.
- R3: With STYLE = 2, the effective enable passes through a latch that is open while clk_in is high, and gclk_out = clk_in OR NOT(latched value). gclk_out rests HIGH while the enable is off.
- R4: With STYLE = 3, gclk_out = clk_in AND the effective enable, with no latch. gclk_out rests LOW while the enable is off.
- R5: The effective enable is func_en OR scan_en. With scan_en = 1 the clock toggles in every style, whatever the value of func_en.
- R6: In the latch styles, an enable change made while the latch is open takes effect at the next active edge, with no extra cycle: the next rising edge for STYLE 0 and the next falling edge for STYLE 2.
- R7: In the latch styles, gclk_out changes only together with a matching clk_in edge. It rises only while clk_in is high and falls only while clk_in is low, so no pulse is shorter than half a clock period, however the enable moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Free-running source clock |
| func_en | input | 1 | Functional clock enable |
| scan_en | input | 1 | Test-mode enable that forces the clock on |
| gclk_out | output | 1 | Gated clock |

## Verification
A latch that opens in the wrong phase, or a latch that is missing, lets an enable change reach the gate while the clock sits at its active level. The result is a pulse on gclk_out that is cut short, or an edge that does not line up with any clk_in edge. This shows in the same half period in which the enable moves. A swapped gate or a swapped inversion shows as the wrong resting level within one half period of the enable dropping. A broken enable merge shows as soon as scan mode is entered with the functional enable low.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

  typedef enum logic [1:0] {
    CGS_LOLATCH_AND = 2'd0,
    CGS_BARE_OR     = 2'd1,
    CGS_HILATCH_OR  = 2'd2,
    CGS_BARE_AND    = 2'd3
  } cgs_style_e;

  localparam int unsigned CGS_STYLE_COUNT = 4;

  function automatic bit cgs_is_latched(input int unsigned style);
    return (style == 0) || (style == 2);
  endfunction

  function automatic bit cgs_uses_or(input int unsigned style);
    return (style == 1) || (style == 2);
  endfunction

  function automatic bit cgs_latch_open_high(input int unsigned style);
    return style == 2;
  endfunction

endpackage

// File: rtl/cgs_enable_merge.sv
module cgs_enable_merge (
  input  logic func_en,
  input  logic scan_en,
  output logic en_eff
);
  assign en_eff = func_en | scan_en;
endmodule

// File: rtl/cgs_enable_latch.sv
module cgs_enable_latch #(
  parameter bit OPEN_HIGH = 1'b0
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  localparam logic OPEN_LEVEL = OPEN_HIGH;

  always_latch begin
    if (clk == OPEN_LEVEL) q = d;
  end
endmodule

// File: rtl/cgs_gate.sv
module cgs_gate #(
  parameter bit USE_OR = 1'b0
) (
  input  logic clk,
  input  logic pass,
  output logic gclk
);
  generate
    if (USE_OR) begin : g_or
      assign gclk = clk | ~pass;
    end else begin : g_and
      assign gclk = clk & pass;
    end
  endgenerate
endmodule

// File: rtl/clk_gate_sel.sv
module clk_gate_sel #(
  parameter int unsigned STYLE = 0
) (
  input  logic clk_in,
  input  logic func_en,
  input  logic scan_en,
  output logic gclk_out
);
  import cgs_pkg::*;

  localparam bit LATCHED   = cgs_is_latched(STYLE);
  localparam bit GATE_OR   = cgs_uses_or(STYLE);
  localparam bit OPEN_HIGH = cgs_latch_open_high(STYLE);

  logic en_eff;
  logic en_gate;

  cgs_enable_merge u_merge (
    .func_en (func_en),
    .scan_en (scan_en),
    .en_eff  (en_eff)
  );

  generate
    if (STYLE >= CGS_STYLE_COUNT) begin : g_bad_style
      $error("clk_gate_sel: STYLE must be 0..3");
    end

    if (LATCHED) begin : g_latch
      cgs_enable_latch #(.OPEN_HIGH(OPEN_HIGH)) u_latch (
        .clk (clk_in),
        .d   (en_eff),
        .q   (en_gate)
      );
    end else begin : g_direct
      assign en_gate = en_eff;
    end
  endgenerate

  cgs_gate #(.USE_OR(GATE_OR)) u_gate (
    .clk  (clk_in),
    .pass (en_gate),
    .gclk (gclk_out)
  );
endmodule

// File: rtl/clk_gate_sel_chk.sv
module clk_gate_sel_chk #(
  parameter int unsigned STYLE = 0
) (
  input logic clk_in,
  input logic gclk_out
);
  logic armed = 1'b0;

  always @(posedge clk_in) armed <= 1'b1;

  always @(posedge gclk_out) begin
    if (armed && (STYLE == 0 || STYLE == 2))
      AST_LATCHED_RISE_IN_HIGH: assert (clk_in == 1'b1); // R7
    if (armed && STYLE == 3)
      AST_BARE_AND_RISE_IN_HIGH: assert (clk_in == 1'b1); // R4
  end

  always @(negedge gclk_out) begin
    if (armed && (STYLE == 0 || STYLE == 2))
      AST_LATCHED_FALL_IN_LOW: assert (clk_in == 1'b0); // R7
    if (armed && STYLE == 1)
      AST_BARE_OR_FALL_IN_LOW: assert (clk_in == 1'b0); // R2
  end
endmodule

bind clk_gate_sel clk_gate_sel_chk #(.STYLE(STYLE)) u_chk (
  .clk_in   (clk_in),
  .gclk_out (gclk_out)
);

// File: tb/clk_gate_sel_test.sv
`timescale 1ns/1ps
module clk_gate_sel_test;
  logic       clk = 1'b0;
  logic [3:0] fen = 4'h0;
  logic [3:0] sen = 4'h0;
  logic       g0, g1, g2, g3;
  logic [3:0] epos = 4'h0, eprev_pos = 4'h0, eneg = 4'h0, eprev_neg = 4'h0;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string force_tag = "";

  always #4 clk = ~clk;

  clk_gate_sel #(.STYLE(0)) uut    (.clk_in(clk), .func_en(fen[0]), .scan_en(sen[0]), .gclk_out(g0));
  clk_gate_sel #(.STYLE(1)) uut_or (.clk_in(clk), .func_en(fen[1]), .scan_en(sen[1]), .gclk_out(g1));
  clk_gate_sel #(.STYLE(2)) uut_hl (.clk_in(clk), .func_en(fen[2]), .scan_en(sen[2]), .gclk_out(g2));
  clk_gate_sel #(.STYLE(3)) uut_an (.clk_in(clk), .func_en(fen[3]), .scan_en(sen[3]), .gclk_out(g3));

  always @(posedge clk) begin eprev_pos = epos; epos = fen | sen; end
  always @(negedge clk) begin eprev_neg = eneg; eneg = fen | sen; end

  realtime last0 = -100.0, last2 = -100.0;
  int short0 = 0, short2 = 0;
  always @(g0) begin if ($realtime - last0 < 3.9 && $realtime > 1.0) short0++; last0 = $realtime; end
  always @(g2) begin if ($realtime - last2 < 3.9 && $realtime > 1.0) short2++; last2 = $realtime; end

  function automatic bit model(int style, bit high_phase, bit now_en, bit pos_en, bit neg_en);
    case (style)
      0: return high_phase ? pos_en : 1'b0;
      1: return high_phase ? 1'b1 : ~now_en;
      2: return high_phase ? 1'b1 : ~neg_en;
      default: return high_phase ? now_en : 1'b0;
    endcase
  endfunction

  task automatic check(bit got, bit exp, string tag, string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic sample(bit high_phase);
    logic [3:0] now_en;
    logic [3:0] got;
    string tag;
    now_en = fen | sen;
    got = {g3, g2, g1, g0};
    for (int i = 0; i < 4; i++) begin
      case (i)
        0: tag = (high_phase && epos[0] != eprev_pos[0]) ? "R6" : "R1";
        1: tag = "R2";
        2: tag = (!high_phase && eneg[2] != eprev_neg[2]) ? "R6" : "R3";
        default: tag = "R4";
      endcase
      if (force_tag != "") tag = force_tag;
      check(got[i], model(i, high_phase, now_en[i], epos[i], eneg[i]), tag,
            $sformatf("style%0d %s phase", i, high_phase ? "high" : "low"));
    end
  endtask

  task automatic maybe_drive(bit rnd);
    if (!rnd) return;
    for (int i = 0; i < 4; i++) begin
      if ($urandom % 3 == 0) fen[i] = ~fen[i];
      sen[i] = ($urandom % 20 == 0);
    end
  endtask

  task automatic run_cycle(bit rnd);
    @(posedge clk);
    #1 maybe_drive(rnd);
    #1 sample(1'b1);
    #1 maybe_drive(rnd);
    #2 maybe_drive(rnd);
    #1 sample(1'b0);
    #1 maybe_drive(rnd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #200000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // disabled interval: every style rests at its idle level (R1 R2 R3 R4)
    repeat (6) run_cycle(1'b0);
    // scan forces the clock on with func_en low (R5)
    force_tag = "R5";
    sen = 4'hF;
    repeat (4) run_cycle(1'b0);
    sen = 4'h0;
    force_tag = "";
    repeat (2) run_cycle(1'b0);
    // open-phase enable, takes effect at the next active edge (R6)
    @(posedge clk); #5 fen = 4'hF;
    repeat (3) run_cycle(1'b0);
    // closed-phase wiggles for latch styles: no short pulse (R7)
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      #1 fen[0] = ~fen[0];
      #2 fen[0] = ~fen[0];
      #2 fen[2] = ~fen[2];
      #2 fen[2] = ~fen[2];
    end
    repeat (2) run_cycle(1'b0);
    // random mix
    repeat (400) run_cycle(1'b1);
    // long idle again
    fen = 4'h0; sen = 4'h0;
    repeat (6) run_cycle(1'b0);
    check(short0 == 0, 1'b1, "R7", "style0 pulse wider than half period");
    check(short2 == 0, 1'b1, "R7", "style2 pulse wider than half period");
    finish_run();
  end
endmodule